// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block collects a wide bus of level-sensitive peripheral interrupt lines and produces one interrupt output per CPU. Every CPU owns a complete bank of registers on a small memory-mapped register bus. A bank holds one enable word and one status word for every 32 input lines. Any input can therefore be steered to any subset of CPUs by setting its enable bit in the matching banks.

Inputs are active-high levels. They pass through a two-flop synchronizer and are never latched. A status bit is the synchronized level ANDed with the enable bit of that CPU. A CPU's output is the registered OR of all its status bits. The block has no priority logic and no vector queue, so the interrupt handler scans every status word of its bank to find the pending lines. Enable words have no set or clear aliases. Software updates them by reading the word, modifying it and writing it back.

The line count (64 or 128) and the CPU count (1 or 2) are parameters. Each bank is 8 bytes per word pair wide, so the bank size follows from the line count.

Top module: `levelIrqAggregator`

## Requirements
- R1: Address map. With W = NUM_IRQ/32 words per bank, bank c starts at byte address c*8*W. Enable word w is at bank offset 4*w and status word w is at bank offset 4*(W+w). Bit b of word w belongs to input line 32*w+b. For the defaults (128 lines, 2 CPUs) this gives enables at 0x00–0x0C, status at 0x10–0x1C, and bank 1 at 0x20.
- R2: After reset every enable bit is 0, every CPU output is 0 and the read data register is 0.
- R3: A write to an enable word replaces all 32 bits of that word, and a later read returns the written value.
- R4: A status word returns the synchronized input levels ANDed with that CPU's enable word. No latching takes place: when an input falls, its status bit clears.
- R5: A change on an input line reaches the status words on the second rising clock edge after the change. It reaches the CPU output on the third rising clock edge after the change.
- R6: A CPU output is 1 exactly when any status bit of its bank was 1 one clock earlier. A write to an enable word therefore changes the output on the clock edge that follows the write edge.
- R7: The banks are independent. A write to one CPU's bank never changes another bank, and the same line can be enabled toward both CPUs at once.
- R8: Writes to status words are ignored and leave every enable word unchanged.
- R9: An access is unmapped when its bank index is NUM_CPU or more, or when address bits [1:0] are not 0. An unmapped read returns 0 and an unmapped write changes nothing.
- R10: Read data is registered. It appears in the cycle after the read strobe and holds its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_IRQ | Active-high level interrupt inputs, asynchronous |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| cpuIrq | output | NUM_CPU | One interrupt output per CPU |

## Verification
Each input pattern is placed in one word and its complement in every other word. A decode that maps bits to the wrong word, or a status that forgets the mask, then returns the complement instead of the expected value. The output latency is counted edge by edge. A missing synchronizer stage makes the output early, and an extra stage makes it late. Writes go to status offsets, to a bank index beyond the last CPU that aliases bank 0 if upper address bits are dropped, and to a misaligned address. A decode that accepts any of these corrupts an enable word that the bench reads back. Dropping an input checks that status is level-following and not latched, and idle cycles after a read catch read data that is not held.

// File: rtl/intcPkg.sv
package intcPkg;
  localparam int WORD_W = 32;

  // Strobes from the address decoder to the datapath
  typedef struct packed {
    logic       enWr;      // write to a mapped enable word
    logic       cpuSel;    // selected bank
    logic [1:0] wordSel;   // selected word inside the bank
    logic       rdStb;     // read strobe: capture read data
    logic       rdHit;     // address is mapped
    logic       rdStatus;  // address is in the status half
  } ctrlStrobe_t;
endpackage

// File: rtl/intcSync.sv
module intcSync #(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;
  logic [1:0]       age;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R5
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    age[1] |-> dout == $past(din, 2));
endmodule

// File: rtl/intcRegDecode.sv
module intcRegDecode
  import intcPkg::*;
#(
  parameter int NUM_IRQ = 128,
  parameter int NUM_CPU = 2,
  parameter int ADDR_W  = 8
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);
  localparam int NUM_WORDS  = NUM_IRQ / WORD_W;
  localparam int WORD_IDX_W = $clog2(NUM_WORDS);
  localparam int BANK_SHIFT = WORD_IDX_W + 3;
  localparam int BANK_W     = ADDR_W - BANK_SHIFT;

  logic                  aligned;
  logic                  isStatus;
  logic                  mapped;
  logic [BANK_W-1:0]     bankIdx;
  logic [WORD_IDX_W-1:0] wordIdx;

  always_comb begin
    aligned  = (busAddr[1:0] == 2'b00);
    bankIdx  = busAddr[ADDR_W-1:BANK_SHIFT];
    isStatus = busAddr[BANK_SHIFT-1];
    wordIdx  = busAddr[BANK_SHIFT-2:2];
    mapped   = aligned && (int'(bankIdx) < NUM_CPU);

    strobe.enWr     = busWrEn && mapped && !isStatus;
    strobe.cpuSel   = bankIdx[0];
    strobe.wordSel  = 2'(wordIdx);
    strobe.rdStb    = busRdEn;
    strobe.rdHit    = mapped;
    strobe.rdStatus = isStatus;
  end
endmodule

// File: rtl/intcBankDatapath.sv
module intcBankDatapath
  import intcPkg::*;
#(
  parameter int NUM_IRQ = 128,
  parameter int NUM_CPU = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        ctrl,
  input  logic [WORD_W-1:0]  wrData,
  input  logic [NUM_IRQ-1:0] irqSync,
  output logic [WORD_W-1:0]  rdData,
  output logic [NUM_CPU-1:0] cpuIrq
);
  localparam int NUM_WORDS = NUM_IRQ / WORD_W;

  logic [NUM_CPU-1:0][NUM_IRQ-1:0] enReg;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0] status;
  logic [WORD_W-1:0]               rdWord;

  // Enable banks: whole-word writes only
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= '0;
    end else if (ctrl.enWr) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        for (int w = 0; w < NUM_WORDS; w++) begin
          if (ctrl.cpuSel == 1'(c) && ctrl.wordSel == 2'(w))
            enReg[c][w*WORD_W +: WORD_W] <= wrData;
        end
      end
    end
  end

  // Masked status and per-CPU output OR
  always_comb begin
    for (int c = 0; c < NUM_CPU; c++)
      status[c] = irqSync & enReg[c];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuIrq <= '0;
    end else begin
      for (int c = 0; c < NUM_CPU; c++)
        cpuIrq[c] <= |status[c];
    end
  end

  // Readback mux
  always_comb begin
    rdWord = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (ctrl.cpuSel == 1'(c) && ctrl.wordSel == 2'(w))
          rdWord = ctrl.rdStatus ? status[c][w*WORD_W +: WORD_W]
                                 : enReg[c][w*WORD_W +: WORD_W];
      end
    end
    if (!ctrl.rdHit) rdWord = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rdData <= '0;
    else if (ctrl.rdStb) rdData <= rdWord;
  end

  // R3
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.enWr |=> $stable(enReg));

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.rdStb && !ctrl.rdHit) |=> rdData == '0);

  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.rdStb |=> $stable(rdData));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpuChk
    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (enReg[c] == '0) |=> !cpuIrq[c]);

    // R4
    irq_has_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      cpuIrq[c] |-> $past(|irqSync));
  end
endmodule

// File: rtl/levelIrqAggregator.sv
module levelIrqAggregator
  import intcPkg::*;
#(
  parameter int NUM_IRQ = 128,
  parameter int NUM_CPU = 2,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  output logic [NUM_CPU-1:0] cpuIrq
);
  if (!((NUM_IRQ == 64 || NUM_IRQ == 128) && (NUM_CPU == 1 || NUM_CPU == 2)))
    begin : g_badParam
      $error("levelIrqAggregator: unsupported NUM_IRQ or NUM_CPU");
    end

  ctrlStrobe_t        strobe;
  logic [NUM_IRQ-1:0] irqSync;

  intcSync #(.WIDTH(NUM_IRQ)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (irqIn),
    .dout (irqSync)
  );

  intcRegDecode #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) uDecode (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  intcBankDatapath #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (strobe),
    .wrData  (busWrData),
    .irqSync (irqSync),
    .rdData  (busRdData),
    .cpuIrq  (cpuIrq)
  );
endmodule

// File: tb/levelIrqAggregator_test.sv
`timescale 1ns/1ps
module levelIrqAggregator_test;
  localparam int NIRQ = 128;
  localparam int NCPU = 2;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NIRQ-1:0] irqIn = '0;
  logic            busWrEn = 1'b0;
  logic            busRdEn = 1'b0;
  logic [7:0]      busAddr = '0;
  logic [31:0]     busWrData = '0;
  logic [31:0]     busRdData;
  logic [NCPU-1:0] cpuIrq;

  int checkCnt = 0;
  int failCnt  = 0;

  always #10 clk = ~clk;

  levelIrqAggregator #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU), .ADDR_W(8)) uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .cpuIrq(cpuIrq)
  );

  // {cpu, word, enable, input word}
  localparam logic [66:0] VEC [0:7] = '{
    {1'b0, 2'd0, 32'hFFFF_FFFF, 32'h0000_0001},
    {1'b0, 2'd1, 32'h0000_FFFF, 32'h1234_5678},
    {1'b0, 2'd2, 32'h8000_0000, 32'h8000_0000},
    {1'b0, 2'd3, 32'hAAAA_AAAA, 32'h5555_5555},
    {1'b1, 2'd0, 32'hF0F0_F0F0, 32'hFFFF_0000},
    {1'b1, 2'd1, 32'h0000_0001, 32'h0000_0000},
    {1'b1, 2'd2, 32'hFFFF_FFFF, 32'hDEAD_BEEF},
    {1'b1, 2'd3, 32'h8000_0001, 32'h8000_0001}
  };

  function automatic logic [7:0] enAddr(input int c, input int w);
    return 8'(c * 32 + 4 * w);
  endfunction

  function automatic logic [7:0] stAddr(input int c, input int w);
    return 8'(c * 32 + 16 + 4 * w);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic clearAll();
    for (int c = 0; c < NCPU; c++)
      for (int w = 0; w < 4; w++) busWrite(enAddr(c, w), 32'h0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] rd2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset state
    check("R2 cpuIrq after reset", 32'(cpuIrq), 32'h0);
    check("R2 read data after reset", busRdData, 32'h0);
    busRead(enAddr(1, 3), rd);
    check("R2 enable word reset", rd, 32'h0);

    // Table walk: R1 R3 R4 R6 R7
    for (int i = 0; i < 8; i++) begin
      logic        vc;
      logic [1:0]  vw;
      logic [31:0] ven, virq;
      {vc, vw, ven, virq} = VEC[i];
      clearAll();
      for (int w = 0; w < 4; w++)
        irqIn[w*32 +: 32] = (w == int'(vw)) ? virq : ~virq;
      busWrite(enAddr(int'(vc), int'(vw)), ven);
      repeat (4) @(negedge clk);
      busRead(stAddr(int'(vc), int'(vw)), rd);
      check("R1 R4 status word", rd, ven & virq);
      busRead(enAddr(int'(vc), int'(vw)), rd);
      check("R3 enable readback", rd, ven);
      check("R6 target cpuIrq", 32'(cpuIrq[vc]), 32'(|(ven & virq)));
      check("R7 other cpuIrq", 32'(cpuIrq[~vc]), 32'h0);
    end

    // R5 input latency through the synchronizer
    clearAll();
    irqIn = '0;
    busWrite(enAddr(0, 0), 32'h0000_0001);
    repeat (4) @(negedge clk);
    check("R5 idle before change", 32'(cpuIrq), 32'h0);
    irqIn[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R5 output still low after two edges", 32'(cpuIrq[0]), 32'h0);
    @(negedge clk);
    check("R5 output high after three edges", 32'(cpuIrq[0]), 32'h1);

    // R4 level, not latched
    irqIn[0] = 1'b0;
    repeat (4) @(negedge clk);
    busRead(stAddr(0, 0), rd);
    check("R4 status clears when input falls", rd, 32'h0);
    check("R4 output clears when input falls", 32'(cpuIrq[0]), 32'h0);

    // R6 enable write latency
    irqIn[40] = 1'b1;
    repeat (4) @(negedge clk);
    busWrite(enAddr(1, 1), 32'h0000_0100);
    check("R6 output not yet high on write edge", 32'(cpuIrq[1]), 32'h0);
    @(negedge clk);
    check("R6 output high one edge after write", 32'(cpuIrq[1]), 32'h1);

    // R7 same line to both CPUs
    busWrite(enAddr(0, 1), 32'h0000_0100);
    repeat (2) @(negedge clk);
    check("R7 both CPUs see shared line", 32'(cpuIrq), 32'h3);
    busWrite(enAddr(0, 1), 32'h0);
    repeat (2) @(negedge clk);
    check("R7 masking cpu0 leaves cpu1", 32'(cpuIrq), 32'h2);
    busRead(enAddr(1, 1), rd);
    check("R7 cpu1 enable untouched", rd, 32'h0000_0100);

    // R8 status writes ignored
    busWrite(stAddr(1, 2), 32'hFFFF_FFFF);
    busWrite(stAddr(0, 0), 32'hFFFF_FFFF);
    busRead(enAddr(1, 2), rd);
    check("R8 enable unaffected by status write", rd, 32'h0);
    busRead(enAddr(0, 0), rd);
    check("R8 cpu0 enable unaffected", rd, 32'h0000_0001);

    // R9 unmapped accesses
    busWrite(enAddr(0, 0), 32'hCAFE_0001);
    busRead(enAddr(0, 0), rd);
    check("R9 preload nonzero read", rd, 32'hCAFE_0001);
    busRead(8'h40, rd);
    check("R9 unmapped bank reads zero", rd, 32'h0);
    busRead(8'h01, rd);
    check("R9 misaligned read zero", rd, 32'h0);
    busWrite(8'h40, 32'h1111_1111);
    busWrite(8'h01, 32'h2222_2222);
    busWrite(8'h62, 32'h3333_3333);
    busRead(enAddr(0, 0), rd);
    check("R9 unmapped writes ignored", rd, 32'hCAFE_0001);

    // R10 read data holds
    busRead(enAddr(1, 1), rd);
    repeat (3) @(negedge clk);
    rd2 = busRdData;
    check("R10 read data held while idle", rd2, 32'h0000_0100);

    summary();
    $finish;
  end
endmodule